// File: doc/BRIEF.md
# Reset Cause Recorder with Software Reset Request

This block is a small register slice. Software uses it to ask for a system reset and to learn why the last reset took place. A 4-bit request field drives a reset request to the power sequencer, but only while it holds the multi-bit true code. Any other pattern, including a corrupted one, leaves the request low. When the power sequencer reports that a reset has completed, hardware returns the field to the false code by itself.

Cause events arrive as single-cycle pulses: low-power exit, a debug-module reset, and one pulse line for each hardware reset source, such as an escalated alert or a watchdog. Each event is held as pending until the completion pulse arrives. At that point every pending cause, plus the software cause if the request field was true, is ORed into a sticky reason register. Software reads that register and clears bits by writing ones to them.

The block's own reset `rst_n` stands for power-on. It is the only path that sets the power-up reason bit. The system resets that the block records do not clear it, so the reason bits outlive the reset they describe.

Top module: `reset_cause_rec`

## Requirements
- R1: After `rst_n` low, the request field reads 4'b1001, the reason register reads 0x01 (only bit 0, power-up, set), `sw_rst_req` is 0 and no cause is pending.
- R2: `sw_rst_req` is 1 exactly when the request field holds 4'b0110. Every other code, e.g. 4'b1111, 4'b0111 or 4'b1001, gives 0.
- R3: A write strobe to address 0 stores `reg_wdata[3:0]` into the request field, visible from the next cycle.
- R4: A completion pulse returns the request field to 4'b1001 in the next cycle. This takes priority over a write to address 0 in the same cycle.
- R5: On a completion pulse, reason bit 3 (software) is set if the request field held 4'b0110 in that cycle.
- R6: A low-power-exit pulse (reason bit 1), a debug-reset pulse (bit 2) or hardware source i (bit 4+i) only marks that cause pending. It reaches the reason register in the cycle after the next completion pulse, and is then no longer pending.
- R7: A cause pulse in the same cycle as a completion pulse is recorded with that completion.
- R8: A write to address 1 clears each reason bit whose `reg_wdata` bit is 1 and leaves the others. Once cleared, bit 0 is never set again except by `rst_n`.
- R9: When a completion sets a reason bit in the same cycle as a write-one-to-clear of that bit, the bit ends up set.
- R10: Reason bits are sticky: bits from earlier completions remain set through later completions.
- R11: Addresses 2 and 3 read zero, and writes to them change neither register.
- R12: `reg_rdata` follows `reg_addr` combinationally, with no clock edge in between. Address 0 returns the field in bits 3:0 and address 1 the reason register in its low bits, with all upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| reg_we | input | 1 | One-cycle write strobe |
| reg_addr | input | AW (2) | Register address: 0 request field, 1 reason register |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Combinational read data for `reg_addr` |
| lp_exit_pulse | input | 1 | Low-power exit cause pulse |
| dbg_rst_pulse | input | 1 | Debug-module reset cause pulse |
| hw_req_pulse | input | N_HW (4) | One pulse line per hardware reset source |
| rst_done_pulse | input | 1 | Reset completion pulse from the power sequencer |
| sw_rst_req | output | 1 | Software reset request to the power sequencer |

## Verification
Two operations can land on the same register in the same cycle. A completion pulse can meet a software write-one-to-clear of the reason register, and it can also meet a software write of the request field. The vector table drives both pairs in one cycle: the clear mask is all ones while a low-power-exit cause completes, and a new field value is written as the completion arrives. It then reads back that the set bit survived and that the field returned to false. Checker properties watch the same priorities on every cycle.

// File: rtl/rcr_pkg.sv
// Package: rcr_pkg
// Shared constants for the reset cause recorder: the multi-bit boolean
// encodings, the fixed reason bit positions and the register addresses.
// Assumes a 4-bit multi-bit boolean with exactly one true code.
package rcr_pkg;

    localparam int          MB_W     = 4;
    localparam logic [3:0]  MB_TRUE  = 4'b0110;
    localparam logic [3:0]  MB_FALSE = 4'b1001;

    // Reason register bit positions (software decodes these)
    localparam int RSN_PWRUP  = 0;
    localparam int RSN_LPEXIT = 1;
    localparam int RSN_DBG    = 2;
    localparam int RSN_SW     = 3;
    localparam int RSN_HW_LSB = 4;

    // Register addresses
    localparam int ADDR_REQ    = 0;
    localparam int ADDR_REASON = 1;

    // True only for the exact multi-bit true code
    function automatic logic mb_is_true(input logic [MB_W-1:0] v);
        return v == MB_TRUE;
    endfunction

endpackage

// File: rtl/rcr_req_field.sv
// Module: rcr_req_field
// Holds the 4-bit software reset request field. Software may store any
// code. A completion pulse forces it back to the false code and takes
// priority over a software write in the same cycle.
// Assumes wr_en and done are single-cycle strobes in the clk domain.
module rcr_req_field
    import rcr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [MB_W-1:0] wr_val,
    input  logic            done,
    output logic [MB_W-1:0] field_q,
    output logic            req_true
);

    logic [MB_W-1:0] field_d;

    // Next-state selection: completion clear beats software write
    always_comb begin
        field_d = field_q;
        if (done) begin
            field_d = MB_FALSE;
        end else if (wr_en) begin
            field_d = wr_val;
        end
    end

    // Field register with synchronous reset to the false code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= MB_FALSE;
        end else begin
            field_q <= field_d;
        end
    end

    // Decode: only the exact true code requests a reset
    assign req_true = mb_is_true(field_q);

endmodule

// File: rtl/rcr_cause_pend.sv
// Module: rcr_cause_pend
// Keeps one pending flag per pulsed reset cause until the next completion.
// The outgoing vector combines pending flags with pulses of the current
// cycle, so a cause arriving together with the completion is reported.
// Assumes pulses are one cycle wide and synchronous to clk.
module rcr_cause_pend #(
    parameter int NC = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] pulse,
    input  logic          done,
    output logic [NC-1:0] cause_now
);

    logic [NC-1:0] pend_q;

    generate
        for (genvar i = 0; i < NC; i++) begin : g_pend
            // Per-cause flag: set by its pulse, cleared by completion
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q[i] <= 1'b0;
                end else if (done) begin
                    pend_q[i] <= 1'b0;
                end else if (pulse[i]) begin
                    pend_q[i] <= 1'b1;
                end
            end

            // Causes due for recording in this cycle
            assign cause_now[i] = pend_q[i] | pulse[i];
        end
    endgenerate

endmodule

// File: rtl/rcr_reason_reg.sv
// Module: rcr_reason_reg
// Sticky reason register, cleared bit by bit by writing ones. A hardware
// set wins over a clear of the same bit in the same cycle. Bit 0 resets
// to 1 and has no hardware set path; the caller keeps set_mask[0] at 0.
// Assumes RW >= 1.
module rcr_reason_reg #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_en,
    input  logic [RW-1:0] clr_mask,
    input  logic          set_en,
    input  logic [RW-1:0] set_mask,
    output logic [RW-1:0] reason_q
);

    localparam logic [RW-1:0] RST_VAL = RW'(1);

    logic [RW-1:0] cleared;
    logic [RW-1:0] reason_d;

    // Apply the clear first, then OR in hardware sets so sets win
    always_comb begin
        cleared  = clr_en ? (reason_q & ~clr_mask) : reason_q;
        reason_d = set_en ? (cleared | set_mask) : cleared;
    end

    // Reason storage with synchronous reset (power-up bit set)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reason_q <= RST_VAL;
        end else begin
            reason_q <= reason_d;
        end
    end

endmodule

// File: rtl/reset_cause_rec.sv
// Module: reset_cause_rec
// Top of the reset cause recorder. Decodes register writes, routes cause
// pulses into pending flags, records causes into the reason register on
// each completion pulse and drives the software reset request.
// Assumes AW >= 2 and 4 + N_HW < DW. Reads are combinational.
module reset_cause_rec
    import rcr_pkg::*;
#(
    parameter int AW   = 2,
    parameter int DW   = 32,
    parameter int N_HW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            lp_exit_pulse,
    input  logic            dbg_rst_pulse,
    input  logic [N_HW-1:0] hw_req_pulse,
    input  logic            rst_done_pulse,
    output logic            sw_rst_req
);

    localparam int RW = RSN_HW_LSB + N_HW;   // reason register width
    localparam int NC = 2 + N_HW;            // pulsed causes

    logic            sel_req;
    logic            sel_reason;
    logic [MB_W-1:0] field_q;
    logic            req_true;
    logic [NC-1:0]   cause_now;
    logic [RW-1:0]   set_mask;
    logic [RW-1:0]   reason_q;
    logic            unused_wdata;

    // Address decode for the two registers
    assign sel_req    = reg_addr == AW'(ADDR_REQ);
    assign sel_reason = reg_addr == AW'(ADDR_REASON);

    rcr_req_field u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we && sel_req),
        .wr_val   (reg_wdata[MB_W-1:0]),
        .done     (rst_done_pulse),
        .field_q  (field_q),
        .req_true (req_true)
    );

    rcr_cause_pend #(.NC(NC)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse     ({hw_req_pulse, dbg_rst_pulse, lp_exit_pulse}),
        .done      (rst_done_pulse),
        .cause_now (cause_now)
    );

    // Map causes onto reason bit positions; power-up bit has no set path
    always_comb begin
        set_mask                         = '0;
        set_mask[RSN_LPEXIT]             = cause_now[0];
        set_mask[RSN_DBG]                = cause_now[1];
        set_mask[RSN_SW]                 = req_true;
        set_mask[RSN_HW_LSB +: N_HW]     = cause_now[2 +: N_HW];
    end

    rcr_reason_reg #(.RW(RW)) u_reason (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (reg_we && sel_reason),
        .clr_mask (reg_wdata[RW-1:0]),
        .set_en   (rst_done_pulse),
        .set_mask (set_mask),
        .reason_q (reason_q)
    );

    // Combinational read mux, unused addresses return zero
    always_comb begin
        reg_rdata = '0;
        if (sel_req) begin
            reg_rdata[MB_W-1:0] = field_q;
        end else if (sel_reason) begin
            reg_rdata[RW-1:0] = reason_q;
        end
    end

    assign sw_rst_req   = req_true;
    assign unused_wdata = ^reg_wdata[DW-1:RW];

endmodule

// File: rtl/reset_cause_rec_chk.sv
// Module: reset_cause_rec_chk
// Property checker for reset_cause_rec, attached by bind below. Observes
// ports plus the reason register state.
module reset_cause_rec_chk #(
    parameter int AW = 2,
    parameter int DW = 32,
    parameter int RW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          lp_exit_pulse,
    input logic          rst_done_pulse,
    input logic          sw_rst_req,
    input logic [RW-1:0] reason_q
);

    // R2: request output agrees with the field as read back
    assert_req_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(0)) |-> (sw_rst_req == (reg_rdata[3:0] == 4'b0110)));

    // R3: a plain write to the field decides the request next cycle
    assert_field_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == AW'(0) && !rst_done_pulse)
        |=> (sw_rst_req == ($past(reg_wdata[3:0]) == 4'b0110)));

    // R4: completion always drops the request
    assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done_pulse |=> !sw_rst_req);

    // R6: without a completion no reason bit becomes set
    assert_no_set_wo_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_done_pulse |=> ((reason_q & ~$past(reason_q)) == '0));

    // R8: power-up bit never rises after reset
    assert_pwrup_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(reason_q[0]));

    // R9: a set in the completion cycle survives a clear of the same bit
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_done_pulse && lp_exit_pulse) |=> reason_q[1]);

    // R11: writes to unused addresses leave the reason register alone
    assert_unused_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr > AW'(1) && !rst_done_pulse) |=> $stable(reason_q));

endmodule

bind reset_cause_rec reset_cause_rec_chk #(.AW(AW), .DW(DW), .RW(RW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .lp_exit_pulse  (lp_exit_pulse),
    .rst_done_pulse (rst_done_pulse),
    .sw_rst_req     (sw_rst_req),
    .reason_q       (reason_q)
);

// File: tb/reset_cause_rec_tb.sv
// Bench for reset_cause_rec: a vector table walked by one loop, then
// directed tests for reset and corner cases.
module reset_cause_rec_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lp_exit_pulse = 1'b0;
    logic        dbg_rst_pulse = 1'b0;
    logic [3:0]  hw_req_pulse = '0;
    logic        rst_done_pulse = 1'b0;
    logic        sw_rst_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    reset_cause_rec u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .lp_exit_pulse  (lp_exit_pulse),
        .dbg_rst_pulse  (dbg_rst_pulse),
        .hw_req_pulse   (hw_req_pulse),
        .rst_done_pulse (rst_done_pulse),
        .sw_rst_req     (sw_rst_req)
    );

    typedef struct packed {
        logic        we;
        logic [1:0]  addr;
        logic [31:0] wdata;
        logic        lp;
        logic        dbg;
        logic [3:0]  hw;
        logic        done;
        logic [1:0]  caddr;
        logic [31:0] exp;
        logic        ereq;
        logic [7:0]  rq;
    } vec_t;

    // Each row: stimulus for one clock, then read caddr and the request.
    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 4'h0, 1'b0, 2'd1, 32'h01, 1'b0, 8'd1},  // R1
        '{1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 32'h09, 1'b0, 8'd1},  // R1
        '{1'b1, 2'd0, 32'h6,  1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 32'h06, 1'b1, 8'd3},  // R3
        '{1'b1, 2'd0, 32'hF,  1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 32'h0F, 1'b0, 8'd2},  // R2
        '{1'b1, 2'd0, 32'h7,  1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 32'h07, 1'b0, 8'd2},  // R2
        '{1'b1, 2'd0, 32'h6,  1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 32'h06, 1'b1, 8'd2},  // R2
        '{1'b0, 2'd0, 32'h0,  1'b1, 1'b0, 4'h0, 1'b0, 2'd1, 32'h01, 1'b1, 8'd6},  // R6 pending
        '{1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 4'h4, 1'b0, 2'd1, 32'h01, 1'b1, 8'd6},  // R6 pending
        '{1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 4'h0, 1'b1, 2'd1, 32'h4B, 1'b0, 8'd5},  // R5
        '{1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 32'h09, 1'b0, 8'd4},  // R4
        '{1'b1, 2'd1, 32'h0A, 1'b0, 1'b0, 4'h0, 1'b0, 2'd1, 32'h41, 1'b0, 8'd8},  // R8
        '{1'b1, 2'd1, 32'h01, 1'b0, 1'b0, 4'h0, 1'b0, 2'd1, 32'h40, 1'b0, 8'd8},  // R8
        '{1'b0, 2'd0, 32'h0,  1'b0, 1'b1, 4'h1, 1'b1, 2'd1, 32'h54, 1'b0, 8'd7},  // R7
        '{1'b1, 2'd0, 32'h6,  1'b0, 1'b0, 4'h0, 1'b0, 2'd1, 32'h54, 1'b1, 8'd10}, // R10
        '{1'b1, 2'd0, 32'h3,  1'b0, 1'b0, 4'h0, 1'b1, 2'd0, 32'h09, 1'b0, 8'd4},  // R4
        '{1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 4'h0, 1'b0, 2'd1, 32'h5C, 1'b0, 8'd5},  // R5
        '{1'b1, 2'd1, 32'hFF, 1'b1, 1'b0, 4'h0, 1'b1, 2'd1, 32'h02, 1'b0, 8'd9},  // R9
        '{1'b1, 2'd2, 32'hFFFFFFFF, 1'b0, 1'b0, 4'h0, 1'b0, 2'd2, 32'h0, 1'b0, 8'd11}, // R11
        '{1'b1, 2'd3, 32'h6,  1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 32'h09, 1'b0, 8'd11}, // R11
        '{1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 4'h0, 1'b0, 2'd1, 32'h02, 1'b0, 8'd11}, // R11
        '{1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 4'h0, 1'b1, 2'd1, 32'h02, 1'b0, 8'd6}   // R6 cleared
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_we = 1'b0; reg_wdata = '0; lp_exit_pulse = 1'b0;
        dbg_rst_pulse = 1'b0; hw_req_pulse = '0; rst_done_pulse = 1'b0;
    endtask

    // Drive one clock of stimulus from negedge, release after the edge
    task automatic step(input logic we, input logic [1:0] addr, input logic [31:0] wd,
                        input logic lp, input logic dbg, input logic [3:0] hw, input logic done);
        @(negedge clk);
        reg_we = we; reg_addr = addr; reg_wdata = wd; lp_exit_pulse = lp;
        dbg_rst_pulse = dbg; hw_req_pulse = hw; rst_done_pulse = done;
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic read_chk(input string tag, input logic [1:0] addr, input logic [31:0] exp);
        reg_addr = addr;
        #0.5;
        check(tag, reg_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d row %0d", TBL[i].rq, i);
            step(TBL[i].we, TBL[i].addr, TBL[i].wdata, TBL[i].lp, TBL[i].dbg,
                 TBL[i].hw, TBL[i].done);
            read_chk(tag, TBL[i].caddr, TBL[i].exp);
            check({tag, " req"}, {31'b0, sw_rst_req}, {31'b0, TBL[i].ereq});
        end

        // R12: read data follows the address without a clock edge
        @(negedge clk);
        reg_addr = 2'd0;
        #0.5;
        check("R12 addr0", reg_rdata, 32'h9);
        reg_addr = 2'd1;
        #0.5;
        check("R12 addr1", reg_rdata, 32'h2);
        reg_addr = 2'd3;
        #0.5;
        check("R12 addr3", reg_rdata, 32'h0);

        // R1: reset mid-run restores field, reason and request
        step(1'b1, 2'd0, 32'h6, 1'b0, 1'b0, 4'h0, 1'b0);
        check("R2 pre-reset req", {31'b0, sw_rst_req}, 32'h1);
        step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 4'h8, 1'b0);   // leave causes pending
        do_reset();
        read_chk("R1 field after reset", 2'd0, 32'h9);
        read_chk("R1 reason after reset", 2'd1, 32'h1);
        check("R1 req after reset", {31'b0, sw_rst_req}, 32'h0);

        // R1: pending causes were dropped by reset, so completion adds nothing
        step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        read_chk("R1 no pending after reset", 2'd1, 32'h1);

        // R6: highest hardware source maps to bit 7
        step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 4'h8, 1'b0);
        step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        read_chk("R6 hw source 3", 2'd1, 32'h81);

        finish_run();
    end

endmodule